// File: doc/BRIEF.md
# Log-Step Parallel Prefix Scan Unit

This block takes a vector of N words, all loaded in one cycle, and returns every running combination of them under one associative operator chosen at launch. In forward mode, output word i is the combination of words 0 through i. In reverse mode, it is the combination of words i through N-1. Either way, the lower-indexed word is always the left operand, so an operator that is associative but not commutative still gives the correct sequence result.

The work is done in place on a register array using a doubling stride. In round j, each lane whose partner lies 2^j positions away (below it in forward mode, above it in reverse mode) replaces its word with the combination of the two. Lanes without such a partner keep their word. Every lane reads the array as it stood at the end of the previous round. After lg N rounds, one clock each, the array holds the answer. A start/done handshake frames the run, and the result port shows the array directly.

Top module: `scan_prefix_unit`

## Requirements
- R1: While reset is high and after it is released, `busy` and `done` are low and `result` is all zeros.
- R2: With `dir` = 0 (forward), lane i of `result` holds w0 op w1 op ... op wi. Lane i occupies bits [i*W +: W] of `load_data` and of `result`, and the lower index is always the left operand.
- R3: With `dir` = 1 (reverse), lane i holds wi op w(i+1) op ... op w(N-1), again with the lower index on the left.
- R4: `op_sel` encodes the operator: 0 add modulo 2^W, 1 multiply modulo 2^W, 2 unsigned max, 3 unsigned min, 4 AND, 5 OR, 6 XOR, 7 keep-left (a op b = a).
- R5: A start is accepted on a clock edge where `start` is high and `busy` is low. `done` is then high for exactly one cycle, lg N clock edges after the accepting edge, and `busy` is high from the accepting edge until that same edge.
- R6: `start` raised while `busy` is high has no effect on the running scan's result or timing.
- R7: Once `done` has pulsed, `result` holds its value until the next accepted start.
- R8: `op_sel`, `dir` and `load_data` are captured only at the accepting edge. Changing them during a run has no effect on that run.
- R9: A start raised in the cycle where `done` is high is accepted, so scans can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only while idle |
| dir | input | 1 | 0 forward scan, 1 reverse scan |
| op_sel | input | 3 | Operator code |
| load_data | input | N*W | Input words, lane i at bits [i*W +: W] |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| result | output | N*W | Scan result, lane i at bits [i*W +: W] |

## Verification
If a lane uses the wrong stride or the wrong operand order, the lane values seen at `done` are wrong. The keep-left operator exposes swapped operands, because it returns the first word in forward mode and each lane's own word in reverse mode. A round counter that is off by one moves the `done` pulse and leaves partial sums in the upper or lower lanes. Both show up at the very first `done` after the fault. If the captured configuration or the idle hold leaks, `result` moves in the idle cycles after `done`, and a few cycles of observation reveal it.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_MAX   = 3'd2,
    OP_MIN   = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_XOR   = 3'd6,
    OP_KEEPL = 3'd7
  } scan_op_e;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } scan_dir_e;

endpackage

// File: rtl/scan_op_unit.sv
`timescale 1ns/1ps
// Combines two words; lhs is always the lower-indexed operand.
module scan_op_unit
  import scan_pkg::*;
#(
  parameter int W = 16
) (
  input  scan_op_e       op,
  input  logic [W-1:0]   lhs,
  input  logic [W-1:0]   rhs,
  output logic [W-1:0]   y
);

  always_comb begin
    y = '0;
    case (op)
      OP_ADD:   y = lhs + rhs;
      OP_MUL:   y = lhs * rhs;
      OP_MAX:   y = (lhs > rhs) ? lhs : rhs;
      OP_MIN:   y = (lhs < rhs) ? lhs : rhs;
      OP_AND:   y = lhs & rhs;
      OP_OR:    y = lhs | rhs;
      OP_XOR:   y = lhs ^ rhs;
      OP_KEEPL: y = lhs;
      default:  y = lhs;
    endcase
  end

endmodule

// File: rtl/scan_round_ctrl.sv
`timescale 1ns/1ps
// Round sequencer: accepts a start while idle, counts ROUNDS rounds, pulses done.
module scan_round_ctrl #(
  parameter int ROUNDS = 3,
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] round
);

  localparam logic [RW-1:0] LAST_ROUND = RW'(ROUNDS - 1);

  logic          busy_q;
  logic          done_q;
  logic [RW-1:0] round_q;

  assign accept = start && !busy_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign round  = round_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      round_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        round_q <= '0;
      end else if (busy_q) begin
        if (round_q == LAST_ROUND) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          round_q <= '0;
        end else begin
          round_q <= round_q + 1'b1;
        end
      end
    end
  end

  // R5: the round index never passes the last round
  assert_round_range_R5: assert property (@(posedge clk) disable iff (rst)
    round_q <= LAST_ROUND);

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5: done only follows a busy cycle and never overlaps busy
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(busy_q) && !busy_q));

  // R6: a run before its last round stays busy whatever start does
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && round_q != LAST_ROUND) |=> (busy_q && !done_q));

  // R5: the round counter restarts at zero on every accepted start
  assert_round_restart_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_q && round_q == '0));

endmodule

// File: rtl/scan_lane.sv
`timescale 1ns/1ps
// One lane of the array: picks its partner at the current stride and combines.
module scan_lane
  import scan_pkg::*;
#(
  parameter int N   = 8,
  parameter int W   = 16,
  parameter int IDX = 0,
  parameter int RW  = 3
) (
  input  logic [N*W-1:0] cur,
  input  logic [RW-1:0]  round,
  input  scan_dir_e      dir,
  input  scan_op_e       op,
  output logic [W-1:0]   nxt
);

  logic [W-1:0] self_v;
  logic [W-1:0] peer_v;
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic [W-1:0] comb_v;
  logic         has_peer;
  int           stride;
  int           pidx;

  always_comb begin
    stride = 1 << round;
    self_v = cur[IDX*W +: W];
    if (dir == DIR_REV) begin
      has_peer = (IDX + stride) < N;
      pidx     = has_peer ? (IDX + stride) : IDX;
    end else begin
      has_peer = IDX >= stride;
      pidx     = has_peer ? (IDX - stride) : IDX;
    end
    peer_v = cur[pidx*W +: W];
    // lower index always on the left
    lhs = (dir == DIR_REV) ? self_v : peer_v;
    rhs = (dir == DIR_REV) ? peer_v : self_v;
  end

  scan_op_unit #(.W(W)) u_op (
    .op  (op),
    .lhs (lhs),
    .rhs (rhs),
    .y   (comb_v)
  );

  assign nxt = has_peer ? comb_v : self_v;

endmodule

// File: rtl/scan_prefix_unit.sv
`timescale 1ns/1ps
module scan_prefix_unit
  import scan_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16,
  localparam int ROUNDS = $clog2(N),
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           dir,
  input  logic [2:0]     op_sel,
  input  logic [N*W-1:0] load_data,
  output logic           busy,
  output logic           done,
  output logic [N*W-1:0] result
);

  logic           accept;
  logic [RW-1:0]  round;
  logic [N*W-1:0] data_q;
  logic [N*W-1:0] next_vec;
  scan_op_e       op_q;
  scan_dir_e      dir_q;

  scan_round_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .done   (done),
    .round  (round)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    scan_lane #(.N(N), .W(W), .IDX(i), .RW(RW)) u_lane (
      .cur   (data_q),
      .round (round),
      .dir   (dir_q),
      .op    (op_q),
      .nxt   (next_vec[i*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      op_q   <= OP_ADD;
      dir_q  <= DIR_FWD;
    end else if (accept) begin
      data_q <= load_data;
      op_q   <= scan_op_e'(op_sel);
      dir_q  <= scan_dir_e'(dir);
    end else if (busy) begin
      data_q <= next_vec;
    end
  end

  assign result = data_q;

  // R7: the result holds while idle and no start arrives
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  // R8: the captured operator and direction stay fixed through a run
  assert_cfg_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> ($stable(op_q) && $stable(dir_q)));

  // R6: a start during a run does not reload the array with load_data
  assert_no_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (result == $past(next_vec)));

endmodule

// File: tb/scan_prefix_unit_tb.sv
`timescale 1ns/1ps
module scan_prefix_unit_tb;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int LG = $clog2(N);

  typedef struct {
    logic [N*W-1:0] res;
    int             acc;
    int             op;
    bit             rev;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           dir = 1'b0;
  logic [2:0]     op_sel = 3'd0;
  logic [N*W-1:0] load_data = '0;
  logic           busy;
  logic           done;
  logic [N*W-1:0] result;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  exp_t sb[$];
  logic [N*W-1:0] last_res = '0;
  logic [31:0]    rng = 32'h1234_5678;

  scan_prefix_unit #(.N(N), .W(W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dir       (dir),
    .op_sel    (op_sel),
    .load_data (load_data),
    .busy      (busy),
    .done      (done),
    .result    (result)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] apply(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      0: return a + b;
      1: return a * b;
      2: return (a > b) ? a : b;
      3: return (a < b) ? a : b;
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      default: return a;
    endcase
  endfunction

  function automatic logic [N*W-1:0] model(input logic [N*W-1:0] d, input int op, input bit rev);
    logic [N*W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] acc;
      acc = d[i*W +: W];
      if (!rev) begin
        for (int k = i - 1; k >= 0; k--) acc = apply(op, d[k*W +: W], acc);
      end else begin
        for (int k = i + 1; k < N; k++) acc = apply(op, acc, d[k*W +: W]);
      end
      r[i*W +: W] = acc;
    end
    return r;
  endfunction

  function automatic logic [N*W-1:0] next_rand();
    logic [N*W-1:0] v;
    for (int i = 0; i < N*W/32 + 1; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      v = {v[N*W-1:0], 32'h0} | {{(N*W-32){1'b0}}, rng};
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 unexpected done", '0, '1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        for (int i = 0; i < N; i++)
          chk(result[i*W +: W] == e.res[i*W +: W], e.rev ? "R3/R4 reverse lane" : "R2/R4 forward lane",
              N*W'(result[i*W +: W]), N*W'(e.res[i*W +: W]));
        chk(cyc - e.acc == LG, "R5 latency", N*W'(cyc - e.acc), N*W'(LG));
        chk(!busy, "R5 busy low at done", N*W'(busy), '0);
        last_res = e.res;
      end
    end
  end

  // driver: launches one scan; b2b starts in the cycle where done is high (R9)
  task automatic launch(input logic [N*W-1:0] d, input int op, input bit rev, input bit b2b);
    exp_t e;
    if (b2b) begin
      @(negedge clk);
      while (!done) @(negedge clk);
    end else begin
      @(negedge clk);
      while (busy) @(negedge clk);
    end
    start     = 1'b1;
    load_data = d;
    op_sel    = 3'(op);
    dir       = rev;
    @(negedge clk);
    e.res = model(d, op, rev);
    e.acc = cyc;
    e.op  = op;
    e.rev = rev;
    sb.push_back(e);
    chk(busy, "R5/R9 busy after accept", N*W'(busy), 1);
    start = 1'b0;
    // R8: scramble inputs during the run
    load_data = next_rand();
    op_sel    = ~op_sel;
    dir       = ~dir;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy, "R1 busy in reset", N*W'(busy), '0);
    chk(!done, "R1 done in reset", N*W'(done), '0);
    chk(result == '0, "R1 result in reset", result, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && result == '0, "R1 after reset", result, '0);

    // R2, R3, R4: every operator in both directions
    for (int op = 0; op < 8; op++) begin
      for (int rev = 0; rev < 2; rev++) begin
        launch(next_rand(), op, rev[0], 1'b0);
      end
    end

    // R4: wrap and unsigned ordering corner cases
    launch({N{8'hFF}}, 0, 1'b0, 1'b0);
    launch({N{8'h03}}, 1, 1'b1, 1'b0);
    launch({8'h00, 8'h80, 8'h7F, 8'hFF, 8'h01, 8'hFE, 8'h10, 8'h00}, 2, 1'b0, 1'b0);
    launch({8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h10, 8'h00, 8'hFF}, 3, 1'b1, 1'b0);

    // R6: start pulses during a run are ignored
    launch(next_rand(), 0, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1;
    load_data = next_rand();
    op_sel = 3'd6;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R6 still busy", N*W'(busy), 1);

    // R9: back-to-back scans
    launch(next_rand(), 1, 1'b1, 1'b1);
    launch(next_rand(), 7, 1'b0, 1'b1);

    // R7: result holds after done
    wait_idle();
    launch(next_rand(), 5, 1'b1, 1'b0);
    wait_idle();
    repeat (4) begin
      load_data = next_rand();
      @(negedge clk);
      chk(result == last_res, "R7 hold after done", result, last_res);
      chk(!done, "R5 done single cycle", N*W'(done), '0);
    end

    wait_idle();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule